// File: doc/BRIEF.md
# Integer Operate Unit

This block is the integer execution stage of a load/store core. It accepts one decoded operation per handshake. Each operation carries a six-bit operation code and a first operand. Its second operand is either a full register value or an eight-bit immediate. The block computes one 64-bit result and offers it downstream together with a write-enable, which tells the register file whether the destination is updated. The block keeps no condition flags. Comparisons and overflow are expressed only through the value written.

The arithmetic path is purely combinational. Its answer is captured in a single result register that is controlled by a two-state machine. In state `ST_EMPTY` the result register holds nothing. In state `ST_FULL` it holds a result that has not yet been taken. The machine has these transitions:
- `ACCEPT` (`ST_EMPTY` to `ST_FULL`): an operation is taken.
- `IDLE` (stays in `ST_EMPTY`): no operation arrives.
- `STALL` (stays in `ST_FULL`): the consumer is not ready.
- `CHAIN` (stays in `ST_FULL`): the consumer takes the held result while a new operation is accepted in the same cycle.
- `DRAIN` (`ST_FULL` to `ST_EMPTY`): the consumer takes the result and nothing new arrives.

Top module: `iop_unit`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: An operation accepted on a clock edge (`in_valid` and `in_ready` both high) is presented with `out_valid`=1 after that edge. While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `out_data`/`out_wen` stay unchanged. `in_ready` is 1 whenever `out_ready` is 1. A held result that is taken with no new operation leaves `out_valid`=0.
- R3: When `in_use_lit`=1, the second operand is `in_lit` zero-extended to 64 bits and `in_b` has no effect. When `in_use_lit`=0, the second operand is `in_b`.
- R4: Code 0 gives a+b and code 1 gives a-b, both modulo 2^64 with no overflow indication.
- R5: Code 2 (add) and code 3 (subtract) use only the low 32 bits of each operand. They write the 32-bit result sign-extended to 64 bits, so 0x7FFFFFFF+1 gives 0xFFFFFFFF80000000.
- R6: The scaled codes multiply the second operand by 4 or by 8 before the operation:
  - quadword add: code 4 (×4), code 5 (×8)
  - quadword subtract: code 6 (×4), code 7 (×8)
  - longword add: code 8 (×4), code 9 (×8)
  - longword subtract: code 10 (×4), code 11 (×8)
  The longword forms (8 to 11) sign-extend their 32-bit result.
- R7: The compare codes write 1 when the condition holds and 0 otherwise: code 12 equal, 13 not equal, 14 signed less-than, 15 signed less-or-equal, 16 unsigned less-than, 17 unsigned less-or-equal.
- R8: The logic codes are 18 a&b, 19 a|b, 20 a^b, 21 a&~b, 22 a|~b and 23 ~(a^b).
- R9: The conditional-move codes test the first operand as a signed value against zero: 24 eq, 25 ne, 26 lt, 27 le, 28 ge, 29 gt. If the condition holds, `out_wen`=1 and `out_data` is the second operand. Otherwise `out_wen`=0 and `out_data`=0.
- R10: Code 30 shifts left logically, code 31 shifts right logically and code 32 shifts right arithmetically. The shift amount is the low 6 bits of the second operand.
- R11: Codes 33 to 63 give `out_wen`=0 and `out_data`=0. All codes 0 to 23 and 30 to 32 give `out_wen`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_op | input | 6 | Operation code |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second register operand |
| in_lit | input | 8 | Immediate second operand |
| in_use_lit | input | 1 | 1 selects the immediate |
| out_valid | output | 1 | Result held and offered |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Result value |
| out_wen | output | 1 | Destination write enable |

## Verification
A wrong control state shows at the ports on the cycle that follows. A result can be lost, shown twice, or overwritten under stall, and each of these changes `out_valid`, `in_ready` or a held `out_data` one edge after the faulty transition. A wrong datapath selection shows in the very next presented result. The sweep crosses every operation code with operand values that sit at the 32-bit and 64-bit sign boundaries, with both operand sources. A miscomputed extension, scale, comparison sign or shift amount therefore differs from the bench's arithmetic expectation within one operation.

// File: rtl/iop_pkg.sv
package iop_pkg;
    localparam int OP_W = 6;

    typedef enum logic [OP_W-1:0] {
        OP_ADD_Q  = 6'd0,
        OP_SUB_Q  = 6'd1,
        OP_ADD_L  = 6'd2,
        OP_SUB_L  = 6'd3,
        OP_ADD4_Q = 6'd4,
        OP_ADD8_Q = 6'd5,
        OP_SUB4_Q = 6'd6,
        OP_SUB8_Q = 6'd7,
        OP_ADD4_L = 6'd8,
        OP_ADD8_L = 6'd9,
        OP_SUB4_L = 6'd10,
        OP_SUB8_L = 6'd11,
        OP_CEQ    = 6'd12,
        OP_CNE    = 6'd13,
        OP_CLT    = 6'd14,
        OP_CLE    = 6'd15,
        OP_CLTU   = 6'd16,
        OP_CLEU   = 6'd17,
        OP_AND    = 6'd18,
        OP_OR     = 6'd19,
        OP_XOR    = 6'd20,
        OP_ANDN   = 6'd21,
        OP_ORN    = 6'd22,
        OP_XNOR   = 6'd23,
        OP_MVEQ   = 6'd24,
        OP_MVNE   = 6'd25,
        OP_MVLT   = 6'd26,
        OP_MVLE   = 6'd27,
        OP_MVGE   = 6'd28,
        OP_MVGT   = 6'd29,
        OP_SHL    = 6'd30,
        OP_SHR    = 6'd31,
        OP_SAR    = 6'd32
    } iop_op_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } iop_state_e;
endpackage

// File: rtl/iop_operand.sv
module iop_operand #(
    parameter int XLEN  = 64,
    parameter int LIT_W = 8
) (
    input  logic [XLEN-1:0]  reg_b,
    input  logic [LIT_W-1:0] lit,
    input  logic             use_lit,
    output logic [XLEN-1:0]  opnd_b
);
    localparam int PAD_W = XLEN - LIT_W;

    always_comb begin
        if (use_lit) begin
            opnd_b = {{PAD_W{1'b0}}, lit};
        end else begin
            opnd_b = reg_b;
        end
    end
endmodule

// File: rtl/iop_alu.sv
module iop_alu
    import iop_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  iop_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] res,
    output logic            wen
);
    localparam int HALF = XLEN / 2;
    localparam int SH_W = $clog2(XLEN);

    logic [XLEN-1:0] b_x4;
    logic [XLEN-1:0] b_x8;
    logic [SH_W-1:0] amt;
    logic            a_zero;
    logic            a_neg;

    assign b_x4   = b << 2;
    assign b_x8   = b << 3;
    assign amt    = b[SH_W-1:0];
    assign a_zero = (a == '0);
    assign a_neg  = a[XLEN-1];

    function automatic logic [XLEN-1:0] to_long(input logic [XLEN-1:0] v);
        return {{HALF{v[HALF-1]}}, v[HALF-1:0]};
    endfunction

    function automatic logic [XLEN-1:0] flag(input logic c);
        return {{(XLEN-1){1'b0}}, c};
    endfunction

    function automatic logic [XLEN-1:0] pick(input logic c, input logic [XLEN-1:0] v);
        return c ? v : '0;
    endfunction

    always_comb begin
        res = '0;
        wen = 1'b1;
        unique case (op)
            OP_ADD_Q:  res = a + b;
            OP_SUB_Q:  res = a - b;
            OP_ADD_L:  res = to_long(a + b);
            OP_SUB_L:  res = to_long(a - b);
            OP_ADD4_Q: res = a + b_x4;
            OP_ADD8_Q: res = a + b_x8;
            OP_SUB4_Q: res = a - b_x4;
            OP_SUB8_Q: res = a - b_x8;
            OP_ADD4_L: res = to_long(a + b_x4);
            OP_ADD8_L: res = to_long(a + b_x8);
            OP_SUB4_L: res = to_long(a - b_x4);
            OP_SUB8_L: res = to_long(a - b_x8);
            OP_CEQ:    res = flag(a == b);
            OP_CNE:    res = flag(a != b);
            OP_CLT:    res = flag($signed(a) <  $signed(b));
            OP_CLE:    res = flag($signed(a) <= $signed(b));
            OP_CLTU:   res = flag(a <  b);
            OP_CLEU:   res = flag(a <= b);
            OP_AND:    res = a & b;
            OP_OR:     res = a | b;
            OP_XOR:    res = a ^ b;
            OP_ANDN:   res = a & ~b;
            OP_ORN:    res = a | ~b;
            OP_XNOR:   res = ~(a ^ b);
            OP_MVEQ: begin wen = a_zero;             res = pick(wen, b); end
            OP_MVNE: begin wen = !a_zero;            res = pick(wen, b); end
            OP_MVLT: begin wen = a_neg;              res = pick(wen, b); end
            OP_MVLE: begin wen = a_neg || a_zero;    res = pick(wen, b); end
            OP_MVGE: begin wen = !a_neg;             res = pick(wen, b); end
            OP_MVGT: begin wen = !a_neg && !a_zero;  res = pick(wen, b); end
            OP_SHL:    res = a << amt;
            OP_SHR:    res = a >> amt;
            OP_SAR:    res = $signed(a) >>> amt;
            default: begin
                res = '0;
                wen = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/iop_ctrl.sv
module iop_ctrl
    import iop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic load
);
    iop_state_e state_q;
    iop_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (in_valid) state_d = ST_FULL;      // ACCEPT, else IDLE
            end
            ST_FULL: begin
                if (out_ready && !in_valid) state_d = ST_EMPTY; // DRAIN
                else state_d = ST_FULL;                          // CHAIN / STALL
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_EMPTY: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
            end
            ST_FULL: begin
                in_ready  = out_ready;
                out_valid = 1'b1;
            end
            default: begin
                in_ready  = 1'b0;
                out_valid = 1'b0;
            end
        endcase
        load = in_valid && in_ready;
    end
endmodule

// File: rtl/iop_unit.sv
module iop_unit
    import iop_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int LIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [OP_W-1:0]   in_op,
    input  logic [XLEN-1:0]   in_a,
    input  logic [XLEN-1:0]   in_b,
    input  logic [LIT_W-1:0]  in_lit,
    input  logic              in_use_lit,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [XLEN-1:0]   out_data,
    output logic              out_wen
);
    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] alu_res;
    logic            alu_wen;
    logic            load;

    iop_operand #(.XLEN(XLEN), .LIT_W(LIT_W)) u_operand (
        .reg_b   (in_b),
        .lit     (in_lit),
        .use_lit (in_use_lit),
        .opnd_b  (opnd_b)
    );

    iop_alu #(.XLEN(XLEN)) u_alu (
        .op  (iop_op_e'(in_op)),
        .a   (in_a),
        .b   (opnd_b),
        .res (alu_res),
        .wen (alu_wen)
    );

    iop_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load      (load)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data <= '0;
            out_wen  <= 1'b0;
        end else if (load) begin
            out_data <= alu_res;
            out_wen  <= alu_wen;
        end
    end
endmodule

// File: rtl/iop_unit_chk.sv
module iop_unit_chk
    import iop_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic [OP_W-1:0] in_op,
    input logic            out_valid,
    input logic            out_ready,
    input logic [XLEN-1:0] out_data,
    input logic            out_wen
);
    localparam int HALF = XLEN / 2;

    logic [OP_W-1:0] held_op;
    logic            held_cmp;
    logic            held_long;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_op <= '0;
        end else if (in_valid && in_ready) begin
            held_op <= in_op;
        end
    end

    assign held_cmp  = (held_op >= 6'd12) && (held_op <= 6'd17);
    assign held_long = (held_op == 6'd2) || (held_op == 6'd3) ||
                       ((held_op >= 6'd8) && (held_op <= 6'd11));

    AST_ACCEPT_PRESENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid); // R2
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_wen))); // R2
    AST_FREE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid || out_ready) |-> in_ready); // R2
    AST_SUPPRESS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_wen) |-> (out_data == '0)); // R9
    AST_CMP_BOOLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && held_cmp) |-> (out_data[XLEN-1:1] == '0)); // R7
    AST_LONG_SIGNEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && held_long) |-> (out_data[XLEN-1:HALF] == {HALF{out_data[HALF-1]}})); // R5
endmodule

bind iop_unit iop_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_op     (in_op),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_wen   (out_wen)
);

// File: tb/iop_unit_bench.sv
`timescale 1ns/1ps
module iop_unit_bench;
    localparam int XLEN = 64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [5:0]  in_op;
    logic [63:0] in_a;
    logic [63:0] in_b;
    logic [7:0]  in_lit;
    logic        in_use_lit;
    logic        out_valid;
    logic        out_ready;
    logic [63:0] out_data;
    logic        out_wen;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    iop_unit #(.XLEN(XLEN)) u_iop_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_lit(in_lit),
        .in_use_lit(in_use_lit), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_wen(out_wen)
    );

    task automatic chk(input string req, input logic [65:0] act, input logic [65:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] corner(input int i);
        case (i)
            0:  return 64'h0;
            1:  return 64'h1;
            2:  return 64'h0000_0000_7FFF_FFFF;
            3:  return 64'h0000_0000_8000_0000;
            4:  return 64'h0000_0000_FFFF_FFFF;
            5:  return 64'h8000_0000_0000_0000;
            6:  return 64'h7FFF_FFFF_FFFF_FFFF;
            7:  return 64'hFFFF_FFFF_FFFF_FFFF;
            8:  return 64'h0123_4567_89AB_CDEF;
            9:  return 64'h0000_0000_0000_0041;
            default: return 64'hFFFF_FFFF_C000_003F;
        endcase
    endfunction

    function automatic string req_of(input int op);
        if (op <= 1)  return "R4";
        if (op <= 3)  return "R5";
        if (op <= 11) return "R6";
        if (op <= 17) return "R7";
        if (op <= 23) return "R8";
        if (op <= 29) return "R9";
        if (op <= 32) return "R10";
        return "R11";
    endfunction

    function automatic logic [64:0] model(input int op, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r;
        logic [31:0] l;
        logic        w;
        logic        c;
        int          sh;
        w  = 1'b1;
        r  = 64'h0;
        l  = 32'h0;
        c  = 1'b0;
        sh = int'(b[5:0]);
        case (op)
            0:  r = a + b;
            1:  r = a - b;
            2:  l = a[31:0] + b[31:0];
            3:  l = a[31:0] - b[31:0];
            4:  r = a + b * 64'd4;
            5:  r = a + b * 64'd8;
            6:  r = a - b * 64'd4;
            7:  r = a - b * 64'd8;
            8:  l = a[31:0] + b[31:0] * 32'd4;
            9:  l = a[31:0] + b[31:0] * 32'd8;
            10: l = a[31:0] - b[31:0] * 32'd4;
            11: l = a[31:0] - b[31:0] * 32'd8;
            12: r = {63'b0, a == b};
            13: r = {63'b0, a != b};
            14: r = {63'b0, $signed(a) < $signed(b)};
            15: r = {63'b0, $signed(a) <= $signed(b)};
            16: r = {63'b0, a < b};
            17: r = {63'b0, a <= b};
            18: r = a & b;
            19: r = a | b;
            20: r = a ^ b;
            21: r = a & ~b;
            22: r = a | ~b;
            23: r = ~(a ^ b);
            30: r = a << sh;
            31: r = a >> sh;
            32: r = 64'($signed(a) >>> sh);
            default: begin end
        endcase
        if ((op >= 2 && op <= 3) || (op >= 8 && op <= 11)) r = {{32{l[31]}}, l};
        if (op >= 24 && op <= 29) begin
            case (op)
                24: c = ($signed(a) == 0);
                25: c = ($signed(a) != 0);
                26: c = ($signed(a) < 0);
                27: c = ($signed(a) <= 0);
                28: c = ($signed(a) >= 0);
                default: c = ($signed(a) > 0);
            endcase
            w = c;
            r = c ? b : 64'h0;
        end
        if (op > 32) begin
            w = 1'b0;
            r = 64'h0;
        end
        return {w, r};
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        rst_n      = 1'b0;
        in_valid   = 1'b0;
        in_op      = 6'd0;
        in_a       = 64'h0;
        in_b       = 64'h0;
        in_lit     = 8'h0;
        in_use_lit = 1'b0;
        out_ready  = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 in reset", {64'b0, out_valid, in_ready}, 66'b01);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {64'b0, out_valid, in_ready}, 66'b01);

        // sweep of codes, corner operands and both operand sources: R3..R11
        for (int op = 0; op < 40; op++) begin
            for (int ia = 0; ia < 11; ia++) begin
                for (int ib = 0; ib < 11; ib++) begin
                    for (int ul = 0; ul < 2; ul++) begin
                        logic [63:0] bv;
                        logic [63:0] eff;
                        logic [64:0] exp;
                        string       tag;
                        bv         = corner(ib);
                        in_op      = 6'(op);
                        in_a       = corner(ia);
                        in_use_lit = ul[0];
                        in_lit     = bv[7:0];
                        in_b       = (ul != 0) ? ~bv : bv;
                        eff        = (ul != 0) ? {56'b0, bv[7:0]} : bv;
                        exp        = model(op, in_a, eff);
                        tag        = (ul != 0) ? {"R3 ", req_of(op)} : req_of(op);
                        in_valid   = 1'b1;
                        @(negedge clk);
                        in_valid   = 1'b0;
                        chk(tag, {out_valid, out_wen, out_data}, {1'b1, exp});
                    end
                end
            end
        end

        // back-pressure: R2
        @(negedge clk);
        out_ready  = 1'b0;
        in_use_lit = 1'b0;
        in_op      = 6'd0;
        in_a       = 64'd5;
        in_b       = 64'd7;
        in_valid   = 1'b1;
        @(negedge clk);
        chk("R2 first result, stalled", {out_valid, in_ready, out_data}, {1'b1, 1'b0, 64'd12});
        in_op = 6'd1;
        in_a  = 64'd10;
        in_b  = 64'd3;
        repeat (2) @(negedge clk);
        chk("R2 held under stall", {out_valid, in_ready, out_data}, {1'b1, 1'b0, 64'd12});
        out_ready = 1'b1;
        #0.5;
        chk("R2 ready follows consumer", {64'b0, out_valid, in_ready}, 66'b11);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 chained result", {out_valid, out_wen, out_data}, {1'b1, 1'b1, 64'd7});
        @(negedge clk);
        chk("R2 drained", {64'b0, out_valid, in_ready}, 66'b01);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end
endmodule